// File: doc/BRIEF.md
# I2C Target Engine with Per-Byte Bus Stall

This block answers as a 7-bit-addressed target on a two-wire serial bus. It sits behind a four-register port of a small processor. Both bus lines arrive as sampled inputs. The block can pull a line low through an output enable, and the line is released when that enable is low. When an address arrives, the block compares it with a programmed address. It acknowledges a match and then moves bytes in or out of its data register. Bits travel most significant first in both directions.

After every byte, the engine raises an interrupt flag and holds the clock line low. The stall lasts until the processor accesses the data register. In receive mode a read of the data register releases it. In transmit mode a write releases it. An interrupt routine can therefore serve each byte at its own pace, because the bus never runs ahead of the software.

The register port uses a 2-bit address:

| Address | Register | Contents |
|---------|----------|----------|
| 0 | data | data byte |
| 1 | own address | own address in bits 7:1; bit 0 is stored but takes no part in the compare |
| 2 | control | bit 0 enable (writable); bit 1 address matched (read-only); bit 2 transmit mode (read-only) |
| 3 | status | bit 0 interrupt flag; bit 1 NACK seen; any write clears both |

Top module: `i2c_stall_target`

## Requirements
- R1: After reset, all four registers read 00h. SCL and SDA are released and irq_o is low.
- R2: Only bits 7:1 of the own-address register take part in the address compare, and bit 0 is ignored. On a mismatch, or while control bit 0 is clear, the block does not ACK, does not hold SCL and does not set the flag.
- R3: On a matching address the block drives ACK and holds SCL low. It sets the flag and sets control bit 1. The data register receives the address byte, and control bit 2 takes the R/W bit.
- R4: Data bits are sent and received MSB first.
- R5: In receive mode, each byte is ACKed, sets the flag and holds SCL low. The byte is placed in the data register. Only a data-register read releases SCL. A data write or a status access leaves SCL held.
- R6: In transmit mode, each byte the master ACKs sets the flag and holds SCL low. Only a data-register write releases SCL, and the written byte is the next one sent. A data read leaves SCL held.
- R7: A master NACK on a transmitted byte releases SDA without a stall. It sets the flag and status bit 1.
- R8: A status write clears the flag and the NACK bit. irq_o follows the flag. When a flag-setting event and a status write fall in the same cycle, the flag stays set.
- R9: A STOP returns the block to idle. Both lines are released and control bit 1 clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data (combinational from the selected register) |
| irq_o | output | 1 | Interrupt, high while the flag is set |

## Verification
The end of a received byte, which sets the flag, and a processor write to the status register, which clears it, can land in the same clock cycle. The bench provokes this by counting the two synchroniser stages and the engine and register stages after its own SCL falling edge. It then places the status write exactly on the edge where the flag is loaded. It checks that irq_o is still low one cycle before that edge and still high after it. Set must win over clear.

// File: rtl/i2c_stall_pkg.sv
package i2c_stall_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_TX_WAIT
  } eng_state_e;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_OWN  = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_MATCH = 1;
  localparam int CTRL_TX    = 2;
  localparam int STAT_FLAG  = 0;
  localparam int STAT_NACK  = 1;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_s, sync_s, last_q;
  assign raw_s = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-2:0], raw_s[g]};
    end
    assign sync_s[g] = pipe_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '1;
    else         last_q <= sync_s;
  end

  assign scl_o      = sync_s[0];
  assign sda_o      = sync_s[1];
  assign scl_rise_o = sync_s[0] & ~last_q[0];
  assign scl_fall_o = ~sync_s[0] & last_q[0];
  // SDA edges only count as START/STOP while SCL stays high
  assign start_o    = sync_s[0] & last_q[0] & last_q[1] & ~sync_s[1];
  assign stop_o     = sync_s[0] & last_q[0] & ~last_q[1] & sync_s[1];
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_stall_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-2:0] own_addr_i,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          data_rd_i,
  input  logic          data_wr_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic          scl_hold_o,
  output logic          sda_oe_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_byte_o,
  output logic          flag_set_o,
  output logic          nack_set_o,
  output logic          matched_o,
  output logic          tx_mode_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);

  eng_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] shreg_q;
  logic          hold_q, sda_oe_q, acked_q, tx_q, match_q;
  logic          rx_valid_q, flag_set_q, nack_set_q;
  logic          release_s;

  // bus stall ends on the data access that matches the transfer direction
  assign release_s = tx_q ? data_wr_i : data_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      shreg_q    <= '0;
      hold_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
      acked_q    <= 1'b0;
      tx_q       <= 1'b0;
      match_q    <= 1'b0;
      rx_valid_q <= 1'b0;
      flag_set_q <= 1'b0;
      nack_set_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      flag_set_q <= 1'b0;
      nack_set_q <= 1'b0;
      if (!en_i || stop_i) begin
        state_q  <= ST_IDLE;
        hold_q   <= 1'b0;
        sda_oe_q <= 1'b0;
        match_q  <= 1'b0;
      end else if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        hold_q   <= 1'b0;
        sda_oe_q <= 1'b0;
        match_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise_i) begin
              shreg_q <= {shreg_q[DW-2:0], sda_s_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == LAST_BIT) begin
              if (shreg_q[DW-1:1] == own_addr_i) begin
                match_q    <= 1'b1;
                tx_q       <= shreg_q[0];
                sda_oe_q   <= 1'b1;
                hold_q     <= 1'b1;
                rx_valid_q <= 1'b1;
                flag_set_q <= 1'b1;
                state_q    <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK, ST_RX_ACK: begin
            if (hold_q && release_s) hold_q <= 1'b0;
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR_ACK && tx_q) begin
                shreg_q  <= tx_byte_i;
                sda_oe_q <= ~tx_byte_i[DW-1];
                state_q  <= ST_TX;
              end else begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise_i) begin
              shreg_q <= {shreg_q[DW-2:0], sda_s_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == LAST_BIT) begin
              sda_oe_q   <= 1'b1;
              hold_q     <= 1'b1;
              rx_valid_q <= 1'b1;
              flag_set_q <= 1'b1;
              state_q    <= ST_RX_ACK;
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == LAST_BIT) begin
                sda_oe_q <= 1'b0;
                state_q  <= ST_TX_ACK;
              end else begin
                sda_oe_q <= ~shreg_q[DW-2];
                shreg_q  <= {shreg_q[DW-2:0], 1'b0};
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              acked_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              flag_set_q <= 1'b1;
              if (acked_q) begin
                hold_q  <= 1'b1;
                state_q <= ST_TX_WAIT;
              end else begin
                nack_set_q <= 1'b1;
                state_q    <= ST_IDLE;
              end
            end
          end
          ST_TX_WAIT: begin
            if (data_wr_i) begin
              hold_q   <= 1'b0;
              shreg_q  <= tx_byte_i;
              sda_oe_q <= ~tx_byte_i[DW-1];
              cnt_q    <= '0;
              state_q  <= ST_TX;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign scl_hold_o = hold_q;
  assign sda_oe_o   = sda_oe_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_byte_o  = shreg_q;
  assign flag_set_o = flag_set_q;
  assign nack_set_o = nack_set_q;
  assign matched_o  = match_q;
  assign tx_mode_o  = tx_q;

  assert_hold_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> $past(data_rd_i || data_wr_i || stop_i || start_i || !en_i));

  assert_stop_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE && !hold_q && !sda_oe_q && !match_q));

  assert_mismatch_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_i && !stop_i && state_q == ST_ADDR && scl_fall_i &&
     cnt_q == LAST_BIT && shreg_q[DW-1:1] != own_addr_i)
    |=> (!hold_q && !sda_oe_q && !flag_set_q));

  assert_sda_scl_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_q != $past(sda_oe_q)) |-> (!$past(scl_s_i) || !$past(en_i)));
endmodule

// File: rtl/i2c_slv_regs.sv
module i2c_slv_regs
  import i2c_stall_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          flag_set_i,
  input  logic          nack_set_i,
  input  logic          matched_i,
  input  logic          tx_mode_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic [DW-2:0] own_addr_o,
  output logic          en_o,
  output logic          data_rd_o,
  output logic          data_wr_o,
  output logic [DW-1:0] tx_byte_o,
  output logic          irq_o
);
  logic [DW-1:0] data_q, own_q;
  logic          en_q, flag_q, nack_q;
  logic          wr_data, wr_own, wr_ctrl, wr_stat;

  assign wr_data = reg_wr_i && reg_addr_i == REG_DATA;
  assign wr_own  = reg_wr_i && reg_addr_i == REG_OWN;
  assign wr_ctrl = reg_wr_i && reg_addr_i == REG_CTRL;
  assign wr_stat = reg_wr_i && reg_addr_i == REG_STAT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      own_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      if (rx_valid_i)   data_q <= rx_byte_i;
      else if (wr_data) data_q <= reg_wdata_i;
      if (wr_own)  own_q <= reg_wdata_i;
      if (wr_ctrl) en_q  <= reg_wdata_i[CTRL_EN];
      // a new event outranks a simultaneous clear
      if (flag_set_i)   flag_q <= 1'b1;
      else if (wr_stat) flag_q <= 1'b0;
      if (nack_set_i)   nack_q <= 1'b1;
      else if (wr_stat) nack_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_DATA: reg_rdata_o = data_q;
      REG_OWN:  reg_rdata_o = own_q;
      REG_CTRL: begin
        reg_rdata_o[CTRL_EN]    = en_q;
        reg_rdata_o[CTRL_MATCH] = matched_i;
        reg_rdata_o[CTRL_TX]    = tx_mode_i;
      end
      REG_STAT: begin
        reg_rdata_o[STAT_FLAG] = flag_q;
        reg_rdata_o[STAT_NACK] = nack_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign own_addr_o = own_q[DW-1:1];
  assign en_o       = en_q;
  assign data_rd_o  = reg_rd_i && reg_addr_i == REG_DATA;
  assign data_wr_o  = wr_data;
  assign tx_byte_o  = wr_data ? reg_wdata_i : data_q;
  assign irq_o      = flag_q;

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_set_i |=> flag_q);

  assert_stat_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !flag_set_i && !nack_set_i) |=> (!flag_q && !nack_q));

  assert_own_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_own |=> $stable(own_q));
endmodule

// File: rtl/i2c_stall_target.sv
module i2c_stall_target #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic          en, data_rd, data_wr, rx_valid, flag_set, nack_set, matched, tx_mode;
  logic [DW-2:0] own_addr;
  logic [DW-1:0] tx_byte, rx_byte, rdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  i2c_slv_engine #(.DW(DW)) u_engine (
    .clk_i, .rst_ni, .en_i(en), .own_addr_i(own_addr),
    .scl_s_i(scl_s), .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev), .data_rd_i(data_rd), .data_wr_i(data_wr),
    .tx_byte_i(tx_byte), .scl_hold_o(scl_oe_o), .sda_oe_o(sda_oe_o),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte), .flag_set_o(flag_set),
    .nack_set_o(nack_set), .matched_o(matched), .tx_mode_o(tx_mode)
  );

  i2c_slv_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i,
    .reg_wdata_i(reg_wdata_i[DW-1:0]),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .flag_set_i(flag_set),
    .nack_set_i(nack_set), .matched_i(matched), .tx_mode_i(tx_mode),
    .reg_rdata_o(rdata), .own_addr_o(own_addr), .en_o(en),
    .data_rd_o(data_rd), .data_wr_o(data_wr), .tx_byte_o(tx_byte), .irq_o
  );

  assign reg_rdata_o = 8'(rdata);
endmodule

// File: tb/i2c_stall_target_tb_top.sv
module i2c_stall_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam int WATCHDOG = 190000;
  localparam logic [6:0] OWN = 7'h3B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, irq;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_line, sda_line;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_stall_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .reg_addr_i(reg_addr),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic m_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b1; m_wait(Q);
    m_scl_low = 1'b1; m_wait(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; m_wait(Q);
    m_scl_low = 1'b0; wait_high(); m_wait(Q);
    m_sda_low = 1'b0; m_wait(Q);
  endtask

  task automatic bit_w(input logic b, input bit tail);
    m_sda_low = ~b; m_wait(Q);
    m_scl_low = 1'b0; wait_high(); m_wait(Q);
    m_scl_low = 1'b1;
    if (tail) m_wait(Q);
  endtask

  task automatic bit_r(output logic b);
    m_sda_low = 1'b0; m_wait(Q);
    m_scl_low = 1'b0; wait_high(); m_wait(Q);
    b = sda_line;
    m_scl_low = 1'b1; m_wait(Q);
  endtask

  task automatic byte_w(input logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_w(d[i], 1'b1);
  endtask

  task automatic byte_r(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    logic b;
    logic [7:0] rx_pat [5];
    logic [7:0] tx_pat [4];
    rx_pat[0] = 8'h00; rx_pat[1] = 8'hFF; rx_pat[2] = 8'hA5; rx_pat[3] = 8'h3C; rx_pat[4] = 8'h81;
    tx_pat[0] = 8'hC3; tx_pat[1] = 8'h01; tx_pat[2] = 8'h80; tx_pat[3] = 8'h5A;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      cpu_rd(2'(r), v);
      chk(v, 0, "R1", $sformatf("reg%0d reset", r));
    end
    chk(scl_oe, 0, "R1", "scl released");
    chk(sda_oe, 0, "R1", "sda released");
    chk(irq, 0, "R1", "irq low");

    cpu_wr(2'd1, {OWN, 1'b1});
    cpu_rd(2'd1, v);
    chk(v, {OWN, 1'b1}, "R2", "own readback");

    // R2 disabled: matching address ignored
    m_start();
    byte_w({OWN, 1'b0});
    chk(scl_oe, 0, "R2", "disabled no hold");
    chk(irq, 0, "R2", "disabled no flag");
    bit_r(b);
    chk(b, 1, "R2", "disabled no ack");
    m_stop();

    cpu_wr(2'd2, 8'h01);

    // R2/R3 full address sweep, own bit0 set but ignored
    for (int a = 0; a < 128; a++) begin
      bit hit;
      hit = (7'(a) == OWN);
      m_start();
      byte_w({7'(a), 1'b0});
      chk(scl_oe, int'(hit), hit ? "R3" : "R2", $sformatf("hold addr %0h", a));
      chk(irq, int'(hit), hit ? "R3" : "R2", $sformatf("flag addr %0h", a));
      cpu_rd(2'd2, v);
      chk(v[1], int'(hit), hit ? "R3" : "R2", $sformatf("matched addr %0h", a));
      if (hit) begin
        chk(sda_oe, 1, "R3", "ack driven");
        chk(v[2], 0, "R3", "write dir");
        cpu_rd(2'd0, v);
        chk(v, {7'(a), 1'b0}, "R3", "addr byte in data");
        chk(scl_oe, 0, "R5", "addr read releases");
        bit_r(b);
        chk(b, 0, "R3", "ack seen");
        m_stop();
        cpu_rd(2'd2, v);
        chk(v[1], 0, "R9", "matched cleared by stop");
        cpu_wr(2'd3, 8'h00);
        chk(irq, 0, "R8", "status write clears");
      end else begin
        bit_r(b);
        chk(b, 1, "R2", $sformatf("nack addr %0h", a));
        m_stop();
      end
    end

    // R4/R5 receive
    m_start();
    byte_w({OWN, 1'b0});
    cpu_rd(2'd0, v);
    bit_r(b);
    cpu_wr(2'd3, 8'h00);
    for (int k = 0; k < 5; k++) begin
      byte_w(rx_pat[k]);
      chk(scl_oe, 1, "R5", "rx hold");
      chk(sda_oe, 1, "R5", "rx ack driven");
      cpu_rd(2'd3, v);
      chk(v, 1, "R5", "rx status");
      chk(scl_oe, 1, "R5", "status read keeps hold");
      cpu_wr(2'd3, 8'h00);
      chk(irq, 0, "R8", "irq cleared");
      chk(scl_oe, 1, "R5", "status write keeps hold");
      cpu_rd(2'd0, v);
      chk(v, rx_pat[k], "R4", "rx byte msb first");
      chk(scl_oe, 0, "R5", "data read releases");
      bit_r(b);
      chk(b, 0, "R5", "rx ack");
    end

    // R8 collision: status write on the cycle the flag is loaded
    for (int i = 7; i >= 1; i--) bit_w(v[i] ^ 1'b1, 1'b1);
    bit_w(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk(irq, 0, "R8", "flag not yet set");
    reg_addr = 2'd3; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(irq, 1, "R8", "set wins over clear");
    chk(scl_oe, 1, "R5", "collision hold");
    cpu_wr(2'd0, 8'h99);
    chk(scl_oe, 1, "R5", "data write keeps rx hold");
    cpu_wr(2'd3, 8'h00);
    chk(irq, 0, "R8", "later clear");
    cpu_rd(2'd0, v);
    chk(v, 8'h99, "R5", "data reg written");
    chk(scl_oe, 0, "R5", "read releases");
    bit_r(b);
    m_stop();
    chk(scl_oe, 0, "R9", "stop scl");
    chk(sda_oe, 0, "R9", "stop sda");

    // R6/R7 transmit
    m_start();
    byte_w({OWN, 1'b1});
    chk(scl_oe, 1, "R3", "read addr hold");
    cpu_rd(2'd2, v);
    chk(v[2], 1, "R3", "tx dir");
    cpu_wr(2'd3, 8'h00);
    cpu_rd(2'd0, v);
    chk(scl_oe, 1, "R6", "data read keeps tx hold");
    cpu_wr(2'd0, tx_pat[0]);
    chk(scl_oe, 0, "R6", "write releases");
    bit_r(b);
    for (int k = 0; k < 4; k++) begin
      byte_r(v);
      chk(v, tx_pat[k], "R4", "tx byte msb first");
      if (k < 3) begin
        bit_w(1'b0, 1'b1);
        chk(scl_oe, 1, "R6", "tx hold");
        chk(irq, 1, "R6", "tx flag");
        cpu_wr(2'd3, 8'h00);
        cpu_rd(2'd0, v);
        chk(scl_oe, 1, "R6", "read keeps hold");
        cpu_wr(2'd0, tx_pat[k+1]);
        chk(scl_oe, 0, "R6", "write releases");
      end else begin
        bit_w(1'b1, 1'b1);
        chk(scl_oe, 0, "R7", "nack no hold");
        chk(sda_oe, 0, "R7", "nack sda released");
        chk(irq, 1, "R7", "nack flag");
        cpu_rd(2'd3, v);
        chk(v, 3, "R7", "nack status");
      end
    end
    m_stop();
    cpu_wr(2'd3, 8'h00);
    cpu_rd(2'd3, v);
    chk(v, 0, "R8", "status cleared");

    done = 1'b1;
    summary();
  end
endmodule